// File: doc/BRIEF.md
# Parallel NOR Flash Erase/Program Sequencer

This block sits on the host side of a 16-bit parallel NOR flash and turns a single request into the bus traffic that the flash needs to erase a sector or to program one word. A request names the operation, the target word address and, for a program, the data word. The sequencer then drives the fixed unlock and command writes, using its own write-cycle timing on chip-enable, write-enable and the data drivers.

After the last command write, the sequencer polls the target address with repeated reads. It finishes when bit 6 of two reads in a row holds the same value. Each operation type has its own limit on polling time. If that limit runs out first, an error pulse is raised and the sequencer returns to idle. While an operation is running, `ready` stays low and no other flash access can start, because the flash cannot serve normal reads during an erase or a program.

Top module: `nor_cmd_seq`

## Requirements
- R1: A request with `reqOp`=1 (erase) produces six writes in this order: 0x00AA to address 0x555, 0x0055 to 0x2AA, 0x0080 to 0x555, 0x00AA to 0x555, 0x0055 to 0x2AA, and 0x0030 to `reqAddr`.
- R2: Each write is one setup cycle (`fCeN`=0, `fWeN`=1), then `WE_LOW` cycles with `fWeN`=0, then one hold cycle (`fWeN`=1). Across all three phases, address and data stay constant, `fDrive`=1 and `fOeN`=1. Consecutive writes follow with no gap.
- R3: A request with `reqOp`=0 (program) produces four writes: 0x00AA to 0x555, 0x0055 to 0x2AA, 0x00A0 to 0x555, then `reqData` to `reqAddr`.
- R4: A `reqStart` pulse is accepted only in a cycle where `ready`=1. `ready` is 0 from the cycle after acceptance up to the cycle that carries `doneStb` or `errStb`, and it is 1 in that cycle. A new request may be accepted in that same cycle.
- R5: Polling begins right after the last write's hold cycle. Each read is `RD_CYC` cycles with `fCeN`=0, `fOeN`=0 and `fDrive`=0, followed by one cycle with `fOeN`=1 and `fCeN`=0. The address is `reqAddr` throughout, and `fWeN` stays 1.
- R6: Bit 6 of `fDataIn` is sampled in the last low-`fOeN` cycle of each read. At the end of a read whose sample equals the previous read's sample, `doneStb` is 1 for the next cycle. At least two reads are always made.
- R7: If polling runs for `PROG_TMO` cycles (program) or `ERASE_TMO` cycles (erase) without completing, `errStb` is 1 for one cycle and the block returns to idle. If completion is detected in the final allowed cycle, completion wins.
- R8: After reset, `fCeN`, `fWeN` and `fOeN` are 1, `fDrive` is 0, `ready` is 1, and `doneStb` and `errStb` are 0.
- R9: A `reqStart` pulse while `ready`=0 is ignored. The bus sequence of the running operation is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqStart | input | 1 | Single-cycle request strobe |
| reqOp | input | 1 | 1 = sector erase, 0 = word program |
| reqAddr | input | ADDR_W | Target word address (any address in the sector, for erase) |
| reqData | input | DATA_W | Word to program |
| ready | output | 1 | Idle and able to accept a request |
| doneStb | output | 1 | One-cycle pulse: operation completed |
| errStb | output | 1 | One-cycle pulse: polling timed out |
| fAddr | output | ADDR_W | Flash address bus |
| fDataOut | output | DATA_W | Value driven onto the flash data bus |
| fDrive | output | 1 | Enable for the host's data bus drivers |
| fDataIn | input | DATA_W | Value read from the flash data bus |
| fCeN | output | 1 | Flash chip enable, active low |
| fWeN | output | 1 | Flash write enable, active low |
| fOeN | output | 1 | Flash output enable, active low |

## Verification
The bench runs programs and erases against a flash model that flips bit 6 for a chosen number of reads. Zero flips shows that the two-read minimum is enforced. Small and large flip counts separate the six-write erase order from the four-write program order, and show that each operation uses its own limit. A program whose polling ends exactly on its limit is set against one that needs one more read, which pins down where completion gives way to timeout. A request issued in the completion cycle, and a stray start during an erase, separate correct acceptance from both dropping and double-starting.

// File: rtl/nor_seq_pkg.sv
package nor_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_PULSE, ST_HOLD, ST_RDLO, ST_RDGAP
  } seqState_t;

  typedef enum logic [1:0] {SEL_555, SEL_2AA, SEL_TGT} addrSel_t;

  typedef struct packed {
    addrSel_t   aSel;
    logic       useUser;
    logic [7:0] code;
  } cmdStep_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;
    logic stepInc;
    logic cntClr;
    logic pollSample;
    logic pollInc;
    logic rdSel;
  } ctlStb_t;

  localparam int ERASE_STEPS = 6;
  localparam int PROG_STEPS  = 4;
  localparam int TOGGLE_BIT  = 6;

  function automatic cmdStep_t stepInfo(input logic isErase, input logic [2:0] step);
    cmdStep_t s;
    case (step)
      3'd0:    s = '{SEL_555, 1'b0, 8'hAA};
      3'd1:    s = '{SEL_2AA, 1'b0, 8'h55};
      3'd2:    s = '{SEL_555, 1'b0, (isErase ? 8'h80 : 8'hA0)};
      3'd3:    s = isErase ? '{SEL_555, 1'b0, 8'hAA} : '{SEL_TGT, 1'b1, 8'h00};
      3'd4:    s = '{SEL_2AA, 1'b0, 8'h55};
      default: s = '{SEL_TGT, 1'b0, 8'h30};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/nor_seq_dp.sv
module nor_seq_dp
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 4,
  parameter int PROG_TMO  = 25000,
  parameter int ERASE_TMO = 750000000
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStb_t           stb,
  input  logic              reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  input  logic [DATA_W-1:0] fDataIn,
  output logic [CNT_W-1:0]  phaseCnt,
  output logic              lastStep,
  output logic              pollMatch,
  output logic              tmoHit,
  output logic [ADDR_W-1:0] fAddr,
  output logic [DATA_W-1:0] fDataOut
);
  localparam int TMO_MAX = (ERASE_TMO > PROG_TMO) ? ERASE_TMO : PROG_TMO;
  localparam int TMO_W   = $clog2(TMO_MAX + 1);

  logic              opErase;
  logic [ADDR_W-1:0] tgtAddr;
  logic [DATA_W-1:0] tgtData;
  logic [2:0]        step;
  logic              lastBit, prevBit;
  logic [1:0]        sampCnt;
  logic [TMO_W-1:0]  tmoCnt;
  logic [TMO_W-1:0]  tmoLast;
  cmdStep_t          cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      opErase  <= 1'b0;
      tgtAddr  <= '0;
      tgtData  <= '0;
      step     <= '0;
      phaseCnt <= '0;
      lastBit  <= 1'b0;
      prevBit  <= 1'b0;
      sampCnt  <= '0;
      tmoCnt   <= '0;
    end else begin
      if (stb.load) begin
        opErase <= reqOp;
        tgtAddr <= reqAddr;
        tgtData <= reqData;
        step    <= '0;
        sampCnt <= '0;
        tmoCnt  <= '0;
      end else begin
        if (stb.stepInc) step <= step + 3'd1;
        if (stb.pollInc) tmoCnt <= tmoCnt + 1'b1;
        if (stb.pollSample) begin
          prevBit <= lastBit;
          lastBit <= fDataIn[TOGGLE_BIT];
          if (sampCnt != 2'd2) sampCnt <= sampCnt + 2'd1;
        end
      end
      phaseCnt <= stb.cntClr ? '0 : phaseCnt + 1'b1;
    end
  end

  assign tmoLast   = opErase ? TMO_W'(ERASE_TMO - 1) : TMO_W'(PROG_TMO - 1);
  assign tmoHit    = (tmoCnt == tmoLast);
  assign pollMatch = (sampCnt == 2'd2) && (lastBit == prevBit);
  assign lastStep  = (step == (opErase ? 3'(ERASE_STEPS - 1) : 3'(PROG_STEPS - 1)));

  always_comb begin
    cur = stepInfo(opErase, step);
    if (stb.rdSel || cur.aSel == SEL_TGT) fAddr = tgtAddr;
    else if (cur.aSel == SEL_555)          fAddr = ADDR_W'(11'h555);
    else                                   fAddr = ADDR_W'(11'h2AA);
    fDataOut = cur.useUser ? tgtData : DATA_W'(cur.code);
  end

endmodule

// File: rtl/nor_seq_ctrl.sv
module nor_seq_ctrl
  import nor_seq_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int WE_LOW = 5,
  parameter int RD_CYC = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqStart,
  input  logic [CNT_W-1:0] phaseCnt,
  input  logic             lastStep,
  input  logic             pollMatch,
  input  logic             tmoHit,
  output ctlStb_t          stb,
  output logic             ready,
  output logic             doneStb,
  output logic             errStb,
  output logic             fCeN,
  output logic             fWeN,
  output logic             fOeN,
  output logic             fDrive
);
  seqState_t state, nxt;
  logic      pulseEnd, readEnd;

  assign pulseEnd = (phaseCnt == CNT_W'(WE_LOW - 1));
  assign readEnd  = (phaseCnt == CNT_W'(RD_CYC - 1));

  always_comb begin
    nxt = state;
    stb = '0;
    case (state)
      ST_IDLE:  if (reqStart) begin nxt = ST_SETUP; stb.load = 1'b1; end
      ST_SETUP: begin nxt = ST_PULSE; stb.cntClr = 1'b1; end
      ST_PULSE: if (pulseEnd) nxt = ST_HOLD;
      ST_HOLD: begin
        if (lastStep) begin nxt = ST_RDLO; stb.cntClr = 1'b1; end
        else begin nxt = ST_SETUP; stb.stepInc = 1'b1; end
      end
      ST_RDLO: begin
        stb.rdSel   = 1'b1;
        stb.pollInc = 1'b1;
        if (tmoHit) nxt = ST_IDLE;
        else if (readEnd) begin nxt = ST_RDGAP; stb.pollSample = 1'b1; end
      end
      ST_RDGAP: begin
        stb.rdSel   = 1'b1;
        stb.pollInc = 1'b1;
        if (pollMatch || tmoHit) nxt = ST_IDLE;
        else begin nxt = ST_RDLO; stb.cntClr = 1'b1; end
      end
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      doneStb <= 1'b0;
      errStb  <= 1'b0;
    end else begin
      state   <= nxt;
      doneStb <= (state == ST_RDGAP) && pollMatch;
      errStb  <= ((state == ST_RDLO) && tmoHit) ||
                 ((state == ST_RDGAP) && !pollMatch && tmoHit);
    end
  end

  assign ready  = (state == ST_IDLE);
  assign fCeN   = (state == ST_IDLE);
  assign fWeN   = (state != ST_PULSE);
  assign fOeN   = (state != ST_RDLO);
  assign fDrive = (state == ST_SETUP) || (state == ST_PULSE) || (state == ST_HOLD);

endmodule

// File: rtl/nor_cmd_seq.sv
module nor_cmd_seq
  import nor_seq_pkg::*;
#(
  parameter int ADDR_W    = 18,
  parameter int DATA_W    = 16,
  parameter int WE_LOW    = 5,
  parameter int RD_CYC    = 10,
  parameter int PROG_TMO  = 25000,
  parameter int ERASE_TMO = 750000000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqStart,
  input  logic              reqOp,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqData,
  output logic              ready,
  output logic              doneStb,
  output logic              errStb,
  output logic [ADDR_W-1:0] fAddr,
  output logic [DATA_W-1:0] fDataOut,
  output logic              fDrive,
  input  logic [DATA_W-1:0] fDataIn,
  output logic              fCeN,
  output logic              fWeN,
  output logic              fOeN
);
  localparam int CNT_MAX = (WE_LOW > RD_CYC) ? WE_LOW : RD_CYC;
  localparam int CNT_W   = ($clog2(CNT_MAX) < 1) ? 1 : $clog2(CNT_MAX);

  ctlStb_t          stb;
  logic [CNT_W-1:0] phaseCnt;
  logic             lastStep, pollMatch, tmoHit;

  nor_seq_ctrl #(.CNT_W(CNT_W), .WE_LOW(WE_LOW), .RD_CYC(RD_CYC)) u_ctrl (
    .clk(clk), .rst(rst), .reqStart(reqStart), .phaseCnt(phaseCnt),
    .lastStep(lastStep), .pollMatch(pollMatch), .tmoHit(tmoHit), .stb(stb),
    .ready(ready), .doneStb(doneStb), .errStb(errStb),
    .fCeN(fCeN), .fWeN(fWeN), .fOeN(fOeN), .fDrive(fDrive)
  );

  nor_seq_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
               .PROG_TMO(PROG_TMO), .ERASE_TMO(ERASE_TMO)) u_dp (
    .clk(clk), .rst(rst), .stb(stb), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .fDataIn(fDataIn), .phaseCnt(phaseCnt),
    .lastStep(lastStep), .pollMatch(pollMatch), .tmoHit(tmoHit),
    .fAddr(fAddr), .fDataOut(fDataOut)
  );

endmodule

// File: rtl/nor_seq_chk.sv
module nor_seq_chk (
  input logic clk,
  input logic rst,
  input logic reqStart,
  input logic ready,
  input logic doneStb,
  input logic errStb,
  input logic fCeN,
  input logic fWeN,
  input logic fOeN,
  input logic fDrive
);
  // R2
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (rst) !fWeN |-> !fCeN);
  // R2
  we_setup_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(fWeN) |-> $past(!fCeN && fWeN && fDrive));
  // R5
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (rst) !(!fOeN && !fWeN));
  // R5
  drive_off_read_chk: assert property (@(posedge clk) disable iff (rst) !fOeN |-> (!fDrive && !fCeN));
  // R7
  single_outcome_chk: assert property (@(posedge clk) disable iff (rst) !(doneStb && errStb));
  // R4
  outcome_ready_chk: assert property (@(posedge clk) disable iff (rst) (doneStb || errStb) |-> ready);
  // R4
  busy_after_start_chk: assert property (@(posedge clk) disable iff (rst) (reqStart && ready) |=> !ready);
endmodule

bind nor_cmd_seq nor_seq_chk u_chk (
  .clk(clk), .rst(rst), .reqStart(reqStart), .ready(ready), .doneStb(doneStb),
  .errStb(errStb), .fCeN(fCeN), .fWeN(fWeN), .fOeN(fOeN), .fDrive(fDrive)
);

// File: tb/tb_nor_cmd_seq.sv
module tb_nor_cmd_seq;
  localparam int AW = 18, DW = 16, WL = 2, RC = 2, PT = 39, ET = 90;

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic          reqStart = 1'b0, reqOp = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqData = '0;
  logic          ready, doneStb, errStb, fDrive, fCeN, fWeN, fOeN;
  logic [AW-1:0] fAddr;
  logic [DW-1:0] fDataOut, fDataIn;

  nor_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .WE_LOW(WL), .RD_CYC(RC),
                .PROG_TMO(PT), .ERASE_TMO(ET)) dut (
    .clk(clk), .rst(rst), .reqStart(reqStart), .reqOp(reqOp), .reqAddr(reqAddr),
    .reqData(reqData), .ready(ready), .doneStb(doneStb), .errStb(errStb),
    .fAddr(fAddr), .fDataOut(fDataOut), .fDrive(fDrive), .fDataIn(fDataIn),
    .fCeN(fCeN), .fWeN(fWeN), .fOeN(fOeN)
  );

  // flash model: bit 6 flips on each read start while busy
  int   busyReads = 0;
  logic tog = 1'b0;
  always @(negedge fOeN) if (busyReads > 0) begin tog = ~tog; busyReads--; end
  assign fDataIn = {8'hC3, 1'b0, tog, 6'h2D};

  typedef struct {
    bit ceN, weN, oeN, drv, rdy, dn, er;
    logic [AW-1:0] a;
    logic [DW-1:0] d;
    string tag;
  } exp_t;

  exp_t q[$];
  int   vecs = 0, bad = 0, cycles = 0, stimK = 0;
  bit   curReady = 1'b1;

  function automatic exp_t mk(bit ce, bit we, bit oe, bit dv, bit rd, bit dn, bit er,
                              logic [AW-1:0] a, logic [DW-1:0] d, string t);
    exp_t e;
    e.ceN = ce; e.weN = we; e.oeN = oe; e.drv = dv; e.rdy = rd; e.dn = dn; e.er = er;
    e.a = a; e.d = d; e.tag = t;
    return e;
  endfunction

  task automatic pushW(logic [AW-1:0] a, logic [DW-1:0] d, string t);
    q.push_back(mk(0, 1, 1, 1, 0, 0, 0, a, d, t));
    for (int i = 0; i < WL; i++) q.push_back(mk(0, 0, 1, 1, 0, 0, 0, a, d, "R2"));
    q.push_back(mk(0, 1, 1, 1, 0, 0, 0, a, d, t));
  endtask

  task automatic buildOp(bit op, logic [AW-1:0] a, logic [DW-1:0] d, int k);
    int reads, pc, lim, n;
    if (op) begin  // R1
      pushW(18'h555, 16'h00AA, "R1"); pushW(18'h2AA, 16'h0055, "R1");
      pushW(18'h555, 16'h0080, "R1"); pushW(18'h555, 16'h00AA, "R1");
      pushW(18'h2AA, 16'h0055, "R1"); pushW(a, 16'h0030, "R1");
    end else begin // R3
      pushW(18'h555, 16'h00AA, "R3"); pushW(18'h2AA, 16'h0055, "R3");
      pushW(18'h555, 16'h00A0, "R3"); pushW(a, d, "R3");
    end
    reads = (k + 1 < 2) ? 2 : k + 1;
    pc    = reads * (RC + 1);
    lim   = op ? ET : PT;
    n     = (pc <= lim) ? pc : lim;
    for (int i = 0; i < n; i++)
      q.push_back(mk(0, 1, ((i % (RC + 1)) < RC) ? 1'b0 : 1'b1, 0, 0, 0, 0, a, '0, "R5"));
    if (pc <= lim) q.push_back(mk(1, 1, 1, 0, 1, 1, 0, '0, '0, "R6"));
    else           q.push_back(mk(1, 1, 1, 0, 1, 0, 1, '0, '0, "R7"));
  endtask

  // R4: model accepts a start only when it expects ready; R9 otherwise ignores
  always @(posedge clk) if (!rst && reqStart && curReady) buildOp(reqOp, reqAddr, reqData, stimK);

  always @(negedge clk) begin
    if (!rst) begin
      exp_t e;
      bit   m;
      e = (q.size() > 0) ? q.pop_front() : mk(1, 1, 1, 0, 1, 0, 0, '0, '0, "R8");
      m = (fCeN !== e.ceN) || (fWeN !== e.weN) || (fOeN !== e.oeN) || (fDrive !== e.drv) ||
          (ready !== e.rdy) || (doneStb !== e.dn) || (errStb !== e.er) ||
          (!e.ceN && fAddr !== e.a) || (e.drv && fDataOut !== e.d);
      vecs++;
      if (m) begin
        bad++;
        $display("FAIL %s t=%0t ce/we/oe/drv/rdy/dn/er act=%b%b%b%b%b%b%b exp=%b%b%b%b%b%b%b addr act=%h exp=%h data act=%h exp=%h",
                 e.tag, $time, fCeN, fWeN, fOeN, fDrive, ready, doneStb, errStb,
                 e.ceN, e.weN, e.oeN, e.drv, e.rdy, e.dn, e.er, fAddr, e.a, fDataOut, e.d);
      end
      curReady = e.rdy;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      bad++;
      $display("FAIL watchdog expired act=%0d cycles exp<=20000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  task automatic waitIdle();
    do begin @(negedge clk); #1; end while (!(curReady && q.size() == 0));
    #1;
  endtask

  task automatic startOp(bit op, logic [AW-1:0] a, logic [DW-1:0] d, int k);
    waitIdle();
    stimK = k; busyReads = k;
    reqOp = op; reqAddr = a; reqData = d; reqStart = 1'b1;
    @(negedge clk); #2 reqStart = 1'b0;
  endtask

  task automatic gap();
    waitIdle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    repeat (4) @(negedge clk);                 // R8 idle after reset
    startOp(0, 18'h12345, 16'hBEEF, 3); gap(); // R3 R2 R5 R6
    startOp(1, 18'h3F012, 16'h0000, 5); gap(); // R1
    startOp(0, 18'h00007, 16'h1234, 0); gap(); // R6 two-read minimum
    startOp(0, 18'h2AAAA, 16'hA5A5, 12); gap();// R7 completion on final allowed cycle
    startOp(0, 18'h15555, 16'h5A5A, 13); gap();// R7 program timeout
    startOp(1, 18'h20000, 16'h0000, 40); gap();// R7 erase timeout uses own limit
    startOp(1, 18'h08000, 16'h0000, 2);        // R4 back-to-back in done cycle
    startOp(0, 18'h08001, 16'hC0DE, 1); gap();
    // R9: stray start during an erase must be ignored
    startOp(1, 18'h10000, 16'h0000, 4);
    repeat (5) @(negedge clk);
    #2 reqStart = 1'b1; reqOp = 1'b0; reqAddr = 18'h3FFFF; reqData = 16'hFFFF;
    @(negedge clk); #2 reqStart = 1'b0;
    gap();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule